// File: doc/BRIEF.md
# Logarithmic 8-bit integer codec

The block converts between 20-bit unsigned integers and 8-bit logarithmic symbols. A symbol carries a 4-bit exponent e in bits [7:4] and a 4-bit mantissa m in bits [3:0], and stands for the integer m·2^e + (2^e − 1)·16. Because of the exponent-dependent offset, the representable integers form one unbroken ladder: sixteen steps of width 1, then sixteen of width 2, and so on up to steps of width 32768. The largest representable integer is 1,015,792 (symbol 0xFF), and the relative error of any encoding stays within 6.25%.

Decoding is purely combinational. Encoding is sequential. A value is accepted with a valid strobe while the encoder is idle. The encoder first estimates the exponent from the position of the leading one of the value. It then corrects that estimate downward or upward, one step per cycle. The truncated mantissa is formed last, and the symbol is returned together with a one-cycle done pulse. Values above the largest representable integer saturate to 0xFF.

Top module: `log8_codec`

## Requirements
- R1: The decoder output equals m·2^e + (2^e − 1)·16, where e = dec_sym_i[7:4] and m = dec_sym_i[3:0]. The output settles within the same cycle, with no clock involved.
- R2: An encoded value below 16 gives the symbol equal to that value (exponent 0, mantissa = value).
- R3: For any value v up to 1,015,792, the encoded symbol s satisfies decode(s) ≤ v. Either s is 0xFF or decode(s+1) > v. The mantissa is therefore truncated toward zero.
- R4: A value of 1,015,792 or more, up to the 20-bit maximum 1,048,575, encodes to 0xFF.
- R5: enc_done_o is high for exactly one cycle per accepted request. enc_sym_o holds the result from that cycle until the next result is produced.
- R6: enc_valid_i is ignored while enc_busy_o is high. The conversion in flight keeps its value, and no extra done pulse follows.
- R7: Counting the clock edge that accepts a request, done rises no more than 16 clock edges later.
- R8: For every symbol s from 0 to 255, encoding decode(s) gives back s.
- R9: After reset, enc_busy_o, enc_done_o and enc_sym_o are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_sym_i | input | 8 | Symbol to decode |
| dec_val_o | output | 20 | Decoded integer (combinational) |
| enc_valid_i | input | 1 | Encode request strobe, taken only while idle |
| enc_val_i | input | 20 | Integer to encode |
| enc_busy_o | output | 1 | Conversion in progress |
| enc_done_o | output | 1 | One-cycle pulse, result valid |
| enc_sym_o | output | 8 | Encoded symbol, held until the next result |

## Verification
The bench looks first at the ladder's rungs. It encodes every decode(s) and also every decode(s) − 1. An encoder whose correction loop stops one step early, or compares with ≥ where it needs <, lands on the neighbouring symbol at exactly these points. Values below 32, where the leading-one estimate is skipped, are swept completely, because a design that applies the estimate there picks the wrong exponent. The top of the range and the values beyond it are also driven. A design without saturation would wrap the mantissa and return a small symbol for these. Finally, a second request is pushed in while the encoder is busy. A design that takes it up would return the wrong symbol or pulse done twice.

// File: rtl/log8_pkg.sv
package log8_pkg;
  localparam int unsigned EXP_W  = 4;
  localparam int unsigned MANT_W = 4;
  localparam int unsigned VAL_W  = 20;

  typedef enum logic {
    ST_IDLE,
    ST_SEARCH
  } enc_state_e;
endpackage

// File: rtl/log8_decoder.sv
module log8_decoder #(
  parameter int unsigned EXP_W  = log8_pkg::EXP_W,
  parameter int unsigned MANT_W = log8_pkg::MANT_W,
  parameter int unsigned VAL_W  = log8_pkg::VAL_W,
  localparam int unsigned SYM_W = EXP_W + MANT_W
) (
  input  logic [SYM_W-1:0] sym_i,
  output logic [VAL_W-1:0] val_o
);
  logic [EXP_W-1:0]  exp_w;
  logic [MANT_W-1:0] mant_w;
  logic [VAL_W-1:0]  ofs_w;
  logic [VAL_W-1:0]  one_w;

  assign exp_w  = sym_i[SYM_W-1:MANT_W];
  assign mant_w = sym_i[MANT_W-1:0];
  assign one_w  = VAL_W'(1);
  // offset = (2^e - 1) << MANT_W
  assign ofs_w  = ((one_w << exp_w) - one_w) << MANT_W;
  assign val_o  = (VAL_W'(mant_w) << exp_w) + ofs_w;
endmodule

// File: rtl/log8_lead_est.sv
module log8_lead_est #(
  parameter int unsigned EXP_W  = log8_pkg::EXP_W,
  parameter int unsigned MANT_W = log8_pkg::MANT_W,
  parameter int unsigned VAL_W  = log8_pkg::VAL_W
) (
  input  logic [VAL_W-1:0] val_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [VAL_W:0]   ofs_o
);
  localparam int E_MAX = (1 << EXP_W) - 1;

  int          msb;
  int          guess;
  logic [VAL_W:0] one_w;

  assign one_w = (VAL_W+1)'(1);

  always_comb begin
    msb = 0;
    for (int i = 0; i < int'(VAL_W); i++) begin
      if (val_i[i]) msb = i;
    end
    guess = 0;
    if (msb >= int'(MANT_W) + 1) begin
      guess = msb - int'(MANT_W);
      if (guess > E_MAX) guess = E_MAX;
    end
    exp_o = EXP_W'(guess);
    ofs_o = ((one_w << exp_o) - one_w) << MANT_W;
  end
endmodule

// File: rtl/log8_encoder.sv
module log8_encoder
  import log8_pkg::*;
#(
  parameter int unsigned EXP_W  = log8_pkg::EXP_W,
  parameter int unsigned MANT_W = log8_pkg::MANT_W,
  parameter int unsigned VAL_W  = log8_pkg::VAL_W,
  localparam int unsigned SYM_W = EXP_W + MANT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [VAL_W-1:0] val_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [SYM_W-1:0] sym_o
);
  localparam int unsigned E_MAX   = (1 << EXP_W) - 1;
  localparam int unsigned M_MAX   = (1 << MANT_W) - 1;
  localparam logic [VAL_W-1:0] MAX_VAL =
      VAL_W'((M_MAX << E_MAX) + (((1 << E_MAX) - 1) << MANT_W));
  localparam logic [VAL_W:0] STEP = (VAL_W+1)'(1 << MANT_W);

  enc_state_e        state_q;
  logic [VAL_W-1:0]  val_q;
  logic [EXP_W-1:0]  exp_q;
  logic [VAL_W:0]    ofs_q;
  logic [SYM_W-1:0]  sym_q;
  logic              done_q;
  logic [4:0]        lat_q;

  logic [VAL_W-1:0]  clamp_w;
  logic [EXP_W-1:0]  est_exp;
  logic [VAL_W:0]    est_ofs;
  logic [VAL_W:0]    nxt_ofs;
  logic              go_down, go_up, finish;
  logic [VAL_W-1:0]  diff_w;
  logic [VAL_W-1:0]  mant_full;

  assign clamp_w = (val_i > MAX_VAL) ? MAX_VAL : val_i;

  log8_lead_est #(
    .EXP_W (EXP_W),
    .MANT_W(MANT_W),
    .VAL_W (VAL_W)
  ) est_i (
    .val_i(clamp_w),
    .exp_o(est_exp),
    .ofs_o(est_ofs)
  );

  assign nxt_ofs   = (ofs_q << 1) + STEP;
  assign go_down   = (exp_q != '0) && ({1'b0, val_q} < ofs_q);
  assign go_up     = (exp_q != EXP_W'(E_MAX)) && ({1'b0, val_q} >= nxt_ofs);
  assign finish    = (state_q == ST_SEARCH) && !go_down && !go_up;
  assign diff_w    = val_q - ofs_q[VAL_W-1:0];
  assign mant_full = diff_w >> exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      val_q   <= '0;
      exp_q   <= '0;
      ofs_q   <= '0;
      sym_q   <= '0;
      done_q  <= 1'b0;
      lat_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (valid_i) begin
            val_q   <= clamp_w;
            exp_q   <= est_exp;
            ofs_q   <= est_ofs;
            lat_q   <= '0;
            state_q <= ST_SEARCH;
          end
        end
        default: begin
          lat_q <= lat_q + 5'd1;
          if (go_down) begin
            exp_q <= exp_q - EXP_W'(1);
            ofs_q <= (ofs_q - STEP) >> 1;
          end else if (go_up) begin
            exp_q <= exp_q + EXP_W'(1);
            ofs_q <= nxt_ofs;
          end else begin
            sym_q   <= {exp_q, mant_full[MANT_W-1:0]};
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == ST_SEARCH);
  assign done_o = done_q;
  assign sym_o  = sym_q;

  // R5: single-cycle done
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R6: captured value untouched while searching
  a_r6_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |=> $stable(val_q));

  // R3: offset never exceeds value at the end of the search
  a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |-> ({1'b0, val_q} >= ofs_q));

  // R3/R4: mantissa fits its field without wrapping
  a_r4_mant_fit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |-> (mant_full <= VAL_W'(M_MAX)));

  // R7: bounded search time
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> (lat_q < 5'd16));
endmodule

// File: rtl/log8_codec.sv
module log8_codec (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  dec_sym_i,
  output logic [19:0] dec_val_o,
  input  logic        enc_valid_i,
  input  logic [19:0] enc_val_i,
  output logic        enc_busy_o,
  output logic        enc_done_o,
  output logic [7:0]  enc_sym_o
);
  log8_decoder #(
    .EXP_W (4),
    .MANT_W(4),
    .VAL_W (20)
  ) dec_i (
    .sym_i(dec_sym_i),
    .val_o(dec_val_o)
  );

  log8_encoder #(
    .EXP_W (4),
    .MANT_W(4),
    .VAL_W (20)
  ) enc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(enc_valid_i),
    .val_i  (enc_val_i),
    .busy_o (enc_busy_o),
    .done_o (enc_done_o),
    .sym_o  (enc_sym_o)
  );
endmodule

// File: tb/log8_codec_tb_top.sv
`timescale 1ns/1ps
module log8_codec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  dec_sym = '0;
  logic [19:0] dec_val;
  logic        enc_valid = 1'b0;
  logic [19:0] enc_val = '0;
  logic        enc_busy, enc_done;
  logic [7:0]  enc_sym;

  int total = 0;
  int bad = 0;
  logic prev_done = 1'b0;

  always #10 clk = ~clk;

  log8_codec dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .dec_sym_i  (dec_sym),
    .dec_val_o  (dec_val),
    .enc_valid_i(enc_valid),
    .enc_val_i  (enc_val),
    .enc_busy_o (enc_busy),
    .enc_done_o (enc_done),
    .enc_sym_o  (enc_sym)
  );

  function automatic int dec_m(int s);
    int e = s >> 4;
    int m = s & 15;
    return m * (1 << e) + ((1 << e) - 1) * 16;
  endfunction

  function automatic int enc_m(int v);
    int r = 0;
    for (int s = 0; s < 256; s++) if (dec_m(s) <= v) r = s;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // per-clock protocol monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done && enc_done) chk(1'b0, "R5 done twice", 1, 0);
      if (enc_done && enc_busy) chk(1'b0, "R5 done while busy", 1, 0);
      prev_done <= enc_done;
    end
  end

  task automatic run_enc(input int v, input int intr, output int sym);
    int lat;
    @(negedge clk);
    enc_valid = 1'b1;
    enc_val   = v[19:0];
    @(negedge clk);
    enc_valid = 1'b0;
    lat = 0;
    if (intr >= 0) begin
      chk(enc_busy == 1'b1, "R6 busy after accept", int'(enc_busy), 1);
      enc_valid = 1'b1;
      enc_val   = intr[19:0];
    end
    while (!enc_done && lat < 40) begin
      @(negedge clk);
      enc_valid = 1'b0;
      lat++;
    end
    enc_valid = 1'b0;
    chk(lat <= 16, "R7 latency", lat, 16);
    sym = int'(enc_sym);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!enc_done, "R5 R6 no extra done", int'(enc_done), 0);
      chk(int'(enc_sym) == sym, "R5 sym held", int'(enc_sym), sym);
    end
  endtask

  task automatic check_val(input int v);
    int s, e;
    run_enc(v, -1, s);
    e = enc_m(v);
    chk(s == e, "R3 symbol", s, e);
    chk(dec_m(s) <= v, "R3 floor", dec_m(s), v);
    if (s < 255) chk(dec_m(s + 1) > v, "R3 next above", dec_m(s + 1), v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s;
    #1;
    // R9
    chk(!enc_busy, "R9 busy", int'(enc_busy), 0);
    chk(!enc_done, "R9 done", int'(enc_done), 0);
    chk(enc_sym == 8'h00, "R9 sym", int'(enc_sym), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!enc_busy && !enc_done, "R9 idle after reset", int'(enc_busy), 0);

    // R1
    for (int k = 0; k < 256; k++) begin
      dec_sym = k[7:0];
      #1;
      chk(int'(dec_val) == dec_m(k), "R1 decode", int'(dec_val), dec_m(k));
    end
    dec_sym = 8'hff;
    #1;
    chk(int'(dec_val) == 1015792, "R1 decode top", int'(dec_val), 1015792);

    // R2
    for (int v = 0; v < 16; v++) begin
      run_enc(v, -1, s);
      chk(s == v, "R2 small", s, v);
    end

    // R8
    for (int k = 0; k < 256; k++) begin
      run_enc(dec_m(k), -1, s);
      chk(s == k, "R8 round trip", s, k);
    end

    // R3 dense low range, rung edges, sparse stride
    for (int v = 0; v < 2048; v++) check_val(v);
    for (int k = 1; k < 256; k++) check_val(dec_m(k) - 1);
    for (int v = 2048; v <= 1015792; v += 4099) check_val(v);

    // R4
    run_enc(1015792, -1, s);
    chk(s == 255, "R4 max", s, 255);
    run_enc(1015793, -1, s);
    chk(s == 255, "R4 above max", s, 255);
    run_enc(1048575, -1, s);
    chk(s == 255, "R4 all ones", s, 255);
    run_enc(1015791, -1, s);
    chk(s == 254, "R4 just below max", s, 254);

    // R6
    run_enc(700000, 5, s);
    chk(s == enc_m(700000), "R6 ignored request", s, enc_m(700000));
    run_enc(40, 1000000, s);
    chk(s == enc_m(40), "R6 ignored request small", s, enc_m(40));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule